// File: doc/BRIEF.md
# Accumulator-file execute unit with skip

This block is the arithmetic and logic stage of a small 8-bit accumulator machine. Each issued operation combines the accumulator with one byte. That byte is either a data-memory operand that has already been read or a literal from the instruction word. The block returns the following:

- the result byte;
- whether the result is written at all;
- whether the result goes back to the memory operand or to the accumulator;
- the new carry, digit-carry and zero flags, each with its own write enable;
- a request to skip the next instruction.

Fetch, the program counter, banking and the memory write itself belong to the surrounding pipeline. The pipeline presents a decoded 5-bit operation code, the destination bit, a bit index, the operand byte, the accumulator and the current flags, with `in_valid` high. All outputs appear registered one clock later.

Top module: `exu_core`

## Requirements
- R1: With `in_valid` high at a rising edge, the outputs for that operation appear after that edge with `out_valid` high. With `in_valid` low, `out_valid` is low on the next cycle. While `rst_n` is low at an edge, every output resets to zero.
- R2: For file operations the result goes to memory when `dst_bit`=1 and to the accumulator when `dst_bit`=0. Store-accumulator and the two bit-modify operations always target memory. Literal operations (codes 20–25) always target the accumulator. The two bit tests write nothing (`result_we`=0). `result` and `result_to_mem` are only meaningful while `result_we`=1.
- R3: Add (file code 7, literal code 24) returns operand+acc. C is the carry out of bit 7, DC is the carry out of bit 3, and Z marks a zero result. All three flags are enabled.
- R4: Subtract (file code 2, literal code 25) returns operand + ~acc + 1. C=1 means no borrow, DC is the carry out of the low-nibble sum, and Z marks a zero result. All three flags are enabled.
- R5: OR (4, 21), AND (5, 22), XOR (6, 23), pass-operand (8), invert (9), increment (10) and decrement (3) enable and update only Z.
- R6: Rotate right (12) gives {C, f[7:1]} with new C=f[0]. Rotate left (13) gives {f[6:0], C} with new C=f[7]. Only C is enabled.
- R7: Nibble swap (14) returns {f[3:0], f[7:4]} and enables no flag.
- R8: Decrement-skip (11) and increment-skip (15) write f−1 or f+1, raise `skip` when that result is zero, and enable no flag.
- R9: Bit clear (16) and bit set (17) change only bit `bit_sel` of the operand and enable no flag.
- R10: Skip-if-clear (18) raises `skip` when operand bit `bit_sel` is 0. Skip-if-set (19) raises `skip` when that bit is 1.
- R11: Store-accumulator (0) returns acc, and load-literal (20) returns the literal; neither enables a flag. Clear (1) returns 0 and enables only Z, which becomes 1.
- R12: Flag vector bit 0 is C, bit 1 is DC and bit 2 is Z. Any flag whose `flags_we` bit is 0 reads back the `flags_in` value of the issuing cycle.
- R13: Codes 26–31 write nothing, raise no skip and enable no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation issued this cycle |
| op | input | 5 | Decoded operation code |
| dst_bit | input | 1 | Destination select for file operations (1 = memory) |
| bit_sel | input | 3 | Bit index for bit operations |
| opnd | input | 8 | Memory operand or literal |
| acc | input | 8 | Accumulator value |
| flags_in | input | 3 | Current flags {Z, DC, C} |
| out_valid | output | 1 | Result of last cycle's operation present |
| result | output | 8 | Result byte |
| result_we | output | 1 | Result is to be written |
| result_to_mem | output | 1 | 1 = write memory operand, 0 = accumulator |
| flags_out | output | 3 | New flags {Z, DC, C} |
| flags_we | output | 3 | Per-flag write enable |
| skip | output | 1 | Skip the next instruction |

## Verification
On every cycle the assertions check several rules. They check the one-cycle valid relationship and the quiet outputs of idle cycles. They check that every flag whose enable is low holds its input value, and that Z agrees with the result whenever Z is enabled. They also check that literal operations never target memory, that digit carry is enabled only by add and subtract, and that skip comes only from the four skip-capable codes. Only the bench's operand sweeps can show the arithmetic values themselves. These include the carry and digit-carry boundaries (0x0F+1, 0xFF+1, equal-operand subtraction), rotation through each carry value, the zero case that triggers increment- and decrement-skip, and bit operations at all eight positions.

// File: rtl/exu_pkg.sv
// Shared types for the execute unit: operation codes, flag positions and
// the decoded control word. Assumes an 8-bit-style accumulator machine.
package exu_pkg;
    localparam int OP_W   = 5;
    localparam int FLAG_N = 3;
    localparam int FLG_C  = 0;
    localparam int FLG_DC = 1;
    localparam int FLG_Z  = 2;

    typedef enum logic [OP_W-1:0] {
        OP_ST_ACC      = 5'd0,
        OP_CLEAR       = 5'd1,
        OP_SUB_F       = 5'd2,
        OP_DEC_F       = 5'd3,
        OP_OR_F        = 5'd4,
        OP_AND_F       = 5'd5,
        OP_XOR_F       = 5'd6,
        OP_ADD_F       = 5'd7,
        OP_PASS_F      = 5'd8,
        OP_INV_F       = 5'd9,
        OP_INC_F       = 5'd10,
        OP_DEC_SKZ     = 5'd11,
        OP_ROR_C       = 5'd12,
        OP_ROL_C       = 5'd13,
        OP_NIB_SWAP    = 5'd14,
        OP_INC_SKZ     = 5'd15,
        OP_BIT_CLR     = 5'd16,
        OP_BIT_SET     = 5'd17,
        OP_SKIP_IF_CLR = 5'd18,
        OP_SKIP_IF_SET = 5'd19,
        OP_LD_LIT      = 5'd20,
        OP_OR_LIT      = 5'd21,
        OP_AND_LIT     = 5'd22,
        OP_XOR_LIT     = 5'd23,
        OP_ADD_LIT     = 5'd24,
        OP_SUB_LIT     = 5'd25
    } exu_op_e;

    typedef enum logic [1:0] {AM_ADD, AM_SUB, AM_INC, AM_DEC} arith_mode_e;

    typedef enum logic [3:0] {
        LU_ACC, LU_ZERO, LU_OR, LU_AND, LU_XOR, LU_OPND,
        LU_INV, LU_ROR, LU_ROL, LU_SWAP, LU_BCLR, LU_BSET
    } logic_fn_e;

    typedef enum logic [1:0] {DST_FIELD, DST_MEM, DST_ACC} dest_rule_e;

    typedef enum logic [1:0] {SK_NONE, SK_ZERO, SK_BIT_LO, SK_BIT_HI} skip_rule_e;

    typedef struct packed {
        logic              wr;
        dest_rule_e        dst;
        logic              use_arith;
        arith_mode_e       am;
        logic_fn_e         lf;
        logic [FLAG_N-1:0] fmask;
        skip_rule_e        sk;
    } exu_ctl_t;

    localparam logic [FLAG_N-1:0] FM_NONE  = 3'b000;
    localparam logic [FLAG_N-1:0] FM_C     = 3'b001;
    localparam logic [FLAG_N-1:0] FM_Z     = 3'b100;
    localparam logic [FLAG_N-1:0] FM_ARITH = 3'b111;
endpackage

// File: rtl/exu_decode.sv
// Operation decoder: maps a 5-bit code to a control word (write, destination
// rule, datapath select, flag-update mask, skip rule). Unknown codes give
// an all-zero word, which writes nothing and touches no flag.
module exu_decode
    import exu_pkg::*;
(
    input  logic [OP_W-1:0] op,
    output exu_ctl_t        ctl
);
    // Purpose: table lookup from code to control word.
    always_comb begin
        ctl = '0;
        case (op)
            OP_ST_ACC:      begin ctl.wr = 1'b1; ctl.dst = DST_MEM; ctl.lf = LU_ACC; end
            OP_CLEAR:       begin ctl.wr = 1'b1; ctl.lf = LU_ZERO; ctl.fmask = FM_Z; end
            OP_SUB_F:       begin ctl.wr = 1'b1; ctl.use_arith = 1'b1; ctl.am = AM_SUB; ctl.fmask = FM_ARITH; end
            OP_DEC_F:       begin ctl.wr = 1'b1; ctl.use_arith = 1'b1; ctl.am = AM_DEC; ctl.fmask = FM_Z; end
            OP_OR_F:        begin ctl.wr = 1'b1; ctl.lf = LU_OR;  ctl.fmask = FM_Z; end
            OP_AND_F:       begin ctl.wr = 1'b1; ctl.lf = LU_AND; ctl.fmask = FM_Z; end
            OP_XOR_F:       begin ctl.wr = 1'b1; ctl.lf = LU_XOR; ctl.fmask = FM_Z; end
            OP_ADD_F:       begin ctl.wr = 1'b1; ctl.use_arith = 1'b1; ctl.am = AM_ADD; ctl.fmask = FM_ARITH; end
            OP_PASS_F:      begin ctl.wr = 1'b1; ctl.lf = LU_OPND; ctl.fmask = FM_Z; end
            OP_INV_F:       begin ctl.wr = 1'b1; ctl.lf = LU_INV;  ctl.fmask = FM_Z; end
            OP_INC_F:       begin ctl.wr = 1'b1; ctl.use_arith = 1'b1; ctl.am = AM_INC; ctl.fmask = FM_Z; end
            OP_DEC_SKZ:     begin ctl.wr = 1'b1; ctl.use_arith = 1'b1; ctl.am = AM_DEC; ctl.sk = SK_ZERO; end
            OP_ROR_C:       begin ctl.wr = 1'b1; ctl.lf = LU_ROR; ctl.fmask = FM_C; end
            OP_ROL_C:       begin ctl.wr = 1'b1; ctl.lf = LU_ROL; ctl.fmask = FM_C; end
            OP_NIB_SWAP:    begin ctl.wr = 1'b1; ctl.lf = LU_SWAP; end
            OP_INC_SKZ:     begin ctl.wr = 1'b1; ctl.use_arith = 1'b1; ctl.am = AM_INC; ctl.sk = SK_ZERO; end
            OP_BIT_CLR:     begin ctl.wr = 1'b1; ctl.dst = DST_MEM; ctl.lf = LU_BCLR; end
            OP_BIT_SET:     begin ctl.wr = 1'b1; ctl.dst = DST_MEM; ctl.lf = LU_BSET; end
            OP_SKIP_IF_CLR: begin ctl.sk = SK_BIT_LO; end
            OP_SKIP_IF_SET: begin ctl.sk = SK_BIT_HI; end
            OP_LD_LIT:      begin ctl.wr = 1'b1; ctl.dst = DST_ACC; ctl.lf = LU_OPND; end
            OP_OR_LIT:      begin ctl.wr = 1'b1; ctl.dst = DST_ACC; ctl.lf = LU_OR;  ctl.fmask = FM_Z; end
            OP_AND_LIT:     begin ctl.wr = 1'b1; ctl.dst = DST_ACC; ctl.lf = LU_AND; ctl.fmask = FM_Z; end
            OP_XOR_LIT:     begin ctl.wr = 1'b1; ctl.dst = DST_ACC; ctl.lf = LU_XOR; ctl.fmask = FM_Z; end
            OP_ADD_LIT:     begin ctl.wr = 1'b1; ctl.dst = DST_ACC; ctl.use_arith = 1'b1; ctl.am = AM_ADD; ctl.fmask = FM_ARITH; end
            OP_SUB_LIT:     begin ctl.wr = 1'b1; ctl.dst = DST_ACC; ctl.use_arith = 1'b1; ctl.am = AM_SUB; ctl.fmask = FM_ARITH; end
            default:        ctl = '0;
        endcase
    end
endmodule

// File: rtl/exu_arith.sv
// Shared adder for add, subtract, increment and decrement. Subtract feeds
// the inverted accumulator with carry-in 1, so carry out means no borrow.
// Assumes DW is even; the half-width carry is the digit carry.
module exu_arith
    import exu_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] opnd,
    input  logic [DW-1:0] acc,
    input  arith_mode_e   mode,
    output logic [DW-1:0] sum,
    output logic          cout,
    output logic          hcout
);
    localparam int HW = DW / 2;

    logic [DW-1:0] addend;
    logic          cin;
    logic [DW:0]   full;
    logic [HW:0]   half;

    // Purpose: pick the second addend and carry-in for the mode.
    always_comb begin
        case (mode)
            AM_ADD:  begin addend = acc;          cin = 1'b0; end
            AM_SUB:  begin addend = ~acc;         cin = 1'b1; end
            AM_INC:  begin addend = '0;           cin = 1'b1; end
            default: begin addend = {DW{1'b1}};   cin = 1'b0; end
        endcase
    end

    assign full  = {1'b0, opnd} + {1'b0, addend} + {{DW{1'b0}}, cin};
    assign half  = {1'b0, opnd[HW-1:0]} + {1'b0, addend[HW-1:0]} + {{HW{1'b0}}, cin};
    assign sum   = full[DW-1:0];
    assign cout  = full[DW];
    assign hcout = half[HW];
endmodule

// File: rtl/exu_logic.sv
// Non-arithmetic datapath: bitwise ops, moves, rotates through carry,
// nibble swap and single-bit set/clear. Also gives the carry a rotate
// shifts out. Assumes DW is even and at least 2.
module exu_logic
    import exu_pkg::*;
#(
    parameter int DW = 8,
    localparam int BW = $clog2(DW)
) (
    input  logic_fn_e     fn,
    input  logic [DW-1:0] opnd,
    input  logic [DW-1:0] acc,
    input  logic          cin,
    input  logic [BW-1:0] bsel,
    output logic [DW-1:0] res,
    output logic          rot_c
);
    localparam int HW = DW / 2;

    logic [DW-1:0] bmask;

    assign bmask = {{(DW-1){1'b0}}, 1'b1} << bsel;

    // Purpose: select the logic result for the function.
    always_comb begin
        case (fn)
            LU_ACC:  res = acc;
            LU_ZERO: res = '0;
            LU_OR:   res = opnd | acc;
            LU_AND:  res = opnd & acc;
            LU_XOR:  res = opnd ^ acc;
            LU_OPND: res = opnd;
            LU_INV:  res = ~opnd;
            LU_ROR:  res = {cin, opnd[DW-1:1]};
            LU_ROL:  res = {opnd[DW-2:0], cin};
            LU_SWAP: res = {opnd[HW-1:0], opnd[DW-1:HW]};
            LU_BCLR: res = opnd & ~bmask;
            LU_BSET: res = opnd | bmask;
            default: res = '0;
        endcase
    end

    // Purpose: carry shifted out by a rotate.
    assign rot_c = (fn == LU_ROR) ? opnd[0] : opnd[DW-1];
endmodule

// File: rtl/exu_core.sv
// Execute unit top: decodes the operation, runs both datapaths, merges
// flags under the per-operation mask, forms destination and skip, and
// registers everything for one cycle of latency. Assumes the operand is
// already read and the caller performs the write using the outputs.
module exu_core
    import exu_pkg::*;
#(
    parameter int DW = 8,
    localparam int BW = $clog2(DW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   op,
    input  logic              dst_bit,
    input  logic [BW-1:0]     bit_sel,
    input  logic [DW-1:0]     opnd,
    input  logic [DW-1:0]     acc,
    input  logic [FLAG_N-1:0] flags_in,
    output logic              out_valid,
    output logic [DW-1:0]     result,
    output logic              result_we,
    output logic              result_to_mem,
    output logic [FLAG_N-1:0] flags_out,
    output logic [FLAG_N-1:0] flags_we,
    output logic              skip
);
    exu_ctl_t          ctl;
    logic [DW-1:0]     a_sum;
    logic              a_cout;
    logic              a_hcout;
    logic [DW-1:0]     l_res;
    logic              l_rotc;
    logic [DW-1:0]     res_c;
    logic [FLAG_N-1:0] nflag;
    logic [FLAG_N-1:0] merged;
    logic              to_mem_c;
    logic              skip_c;

    exu_decode u_dec (.op(op), .ctl(ctl));

    exu_arith #(.DW(DW)) u_arith (
        .opnd(opnd), .acc(acc), .mode(ctl.am),
        .sum(a_sum), .cout(a_cout), .hcout(a_hcout)
    );

    exu_logic #(.DW(DW)) u_logic (
        .fn(ctl.lf), .opnd(opnd), .acc(acc), .cin(flags_in[FLG_C]),
        .bsel(bit_sel), .res(l_res), .rot_c(l_rotc)
    );

    // Purpose: choose the datapath result.
    assign res_c = ctl.use_arith ? a_sum : l_res;

    // Purpose: candidate flag values before masking.
    assign nflag[FLG_C]  = ctl.use_arith ? a_cout : l_rotc;
    assign nflag[FLG_DC] = a_hcout;
    assign nflag[FLG_Z]  = (res_c == '0);

    // Purpose: per-flag merge, keep the incoming value when not enabled.
    for (genvar k = 0; k < FLAG_N; k++) begin : g_flag
        assign merged[k] = ctl.fmask[k] ? nflag[k] : flags_in[k];
    end

    // Purpose: resolve the destination rule.
    always_comb begin
        case (ctl.dst)
            DST_MEM: to_mem_c = 1'b1;
            DST_ACC: to_mem_c = 1'b0;
            default: to_mem_c = dst_bit;
        endcase
    end

    // Purpose: resolve the skip rule.
    always_comb begin
        case (ctl.sk)
            SK_ZERO:   skip_c = (res_c == '0);
            SK_BIT_LO: skip_c = ~opnd[bit_sel];
            SK_BIT_HI: skip_c = opnd[bit_sel];
            default:   skip_c = 1'b0;
        endcase
    end

    // Purpose: output register stage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            result        <= '0;
            result_we     <= 1'b0;
            result_to_mem <= 1'b0;
            flags_out     <= '0;
            flags_we      <= '0;
            skip          <= 1'b0;
        end else begin
            out_valid     <= in_valid;
            result        <= res_c;
            result_we     <= in_valid & ctl.wr;
            result_to_mem <= to_mem_c;
            flags_out     <= merged;
            flags_we      <= in_valid ? ctl.fmask : '0;
            skip          <= in_valid & skip_c;
        end
    end

    // R1: valid follows the issuing cycle by one clock.
    a_r1_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    // R13 / R1: idle cycles produce no write, no flag enable, no skip.
    a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (flags_we == '0 && !skip && !result_we));

    // R12: an unenabled flag carries the incoming value through.
    a_r12_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (((flags_out ^ $past(flags_in)) & ~flags_we) == '0));

    // R5: zero flag, whenever enabled, agrees with the registered result.
    a_r5_z_matches: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flags_we[FLG_Z]) |-> (flags_out[FLG_Z] == (result == '0)));

    // R2: literal operations always write the accumulator.
    a_r2_lit_to_acc: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(op) >= OP_LD_LIT && $past(op) <= OP_SUB_LIT)
            |-> (result_we && !result_to_mem));

    // R3: digit carry is only ever enabled by add or subtract.
    a_r3_dc_arith_only: assert property (@(posedge clk) disable iff (!rst_n)
        flags_we[FLG_DC] |-> ($past(op) == OP_ADD_F || $past(op) == OP_SUB_F ||
                              $past(op) == OP_ADD_LIT || $past(op) == OP_SUB_LIT));

    // R8 / R10: skip comes only from the skip-capable codes.
    a_r8_skip_source: assert property (@(posedge clk) disable iff (!rst_n)
        skip |-> ($past(op) == OP_DEC_SKZ || $past(op) == OP_INC_SKZ ||
                  $past(op) == OP_SKIP_IF_CLR || $past(op) == OP_SKIP_IF_SET));
endmodule

// File: tb/tb_exu_core.sv
// Scoreboard bench: the driver computes expected outputs from the
// requirements and queues them; a monitor compares them at negedges.
module tb_exu_core;
    import exu_pkg::*;

    localparam int DW = 8;
    localparam int BW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [4:0]    op = '0;
    logic          dst_bit = 1'b0;
    logic [BW-1:0] bit_sel = '0;
    logic [DW-1:0] opnd = '0;
    logic [DW-1:0] acc = '0;
    logic [2:0]    flags_in = '0;
    logic          out_valid;
    logic [DW-1:0] result;
    logic          result_we;
    logic          result_to_mem;
    logic [2:0]    flags_out;
    logic [2:0]    flags_we;
    logic          skip;

    exu_core #(.DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .dst_bit(dst_bit), .bit_sel(bit_sel), .opnd(opnd), .acc(acc),
        .flags_in(flags_in), .out_valid(out_valid), .result(result),
        .result_we(result_we), .result_to_mem(result_to_mem),
        .flags_out(flags_out), .flags_we(flags_we), .skip(skip)
    );

    always #2 clk = ~clk;

    typedef struct packed {
        logic [7:0] res;
        logic       rwe;
        logic       mem;
        logic [2:0] fl;
        logic [2:0] fwe;
        logic       sk;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    total = 0;
    int    bad = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exv);
        end
    endtask

    function automatic exp_t model(input logic [4:0] o, input logic d, input logic [2:0] b,
                                   input logic [7:0] f, input logic [7:0] w, input logic [2:0] fi);
        exp_t e;
        logic [8:0] s;
        logic [4:0] h;
        e = '0;
        e.fl = fi;
        case (o)
            5'd0:  begin e.res = w; e.rwe = 1; e.mem = 1; end
            5'd1:  begin e.res = 8'h00; e.rwe = 1; e.mem = d; e.fwe = 3'b100; end
            5'd2, 5'd25: begin
                s = {1'b0, f} + {1'b0, ~w} + 9'd1;
                h = {1'b0, f[3:0]} + {1'b0, ~w[3:0]} + 5'd1;
                e.res = s[7:0]; e.rwe = 1; e.mem = (o == 5'd2) ? d : 1'b0;
                e.fwe = 3'b111; e.fl[0] = s[8]; e.fl[1] = h[4];
            end
            5'd7, 5'd24: begin
                s = {1'b0, f} + {1'b0, w};
                h = {1'b0, f[3:0]} + {1'b0, w[3:0]};
                e.res = s[7:0]; e.rwe = 1; e.mem = (o == 5'd7) ? d : 1'b0;
                e.fwe = 3'b111; e.fl[0] = s[8]; e.fl[1] = h[4];
            end
            5'd3:  begin e.res = f - 8'd1; e.rwe = 1; e.mem = d; e.fwe = 3'b100; end
            5'd10: begin e.res = f + 8'd1; e.rwe = 1; e.mem = d; e.fwe = 3'b100; end
            5'd4:  begin e.res = f | w; e.rwe = 1; e.mem = d; e.fwe = 3'b100; end
            5'd5:  begin e.res = f & w; e.rwe = 1; e.mem = d; e.fwe = 3'b100; end
            5'd6:  begin e.res = f ^ w; e.rwe = 1; e.mem = d; e.fwe = 3'b100; end
            5'd8:  begin e.res = f; e.rwe = 1; e.mem = d; e.fwe = 3'b100; end
            5'd9:  begin e.res = ~f; e.rwe = 1; e.mem = d; e.fwe = 3'b100; end
            5'd21: begin e.res = f | w; e.rwe = 1; e.fwe = 3'b100; end
            5'd22: begin e.res = f & w; e.rwe = 1; e.fwe = 3'b100; end
            5'd23: begin e.res = f ^ w; e.rwe = 1; e.fwe = 3'b100; end
            5'd20: begin e.res = f; e.rwe = 1; end
            5'd11: begin e.res = f - 8'd1; e.rwe = 1; e.mem = d; e.sk = (e.res == 8'h00); end
            5'd15: begin e.res = f + 8'd1; e.rwe = 1; e.mem = d; e.sk = (e.res == 8'h00); end
            5'd12: begin e.res = {fi[0], f[7:1]}; e.rwe = 1; e.mem = d; e.fwe = 3'b001; e.fl[0] = f[0]; end
            5'd13: begin e.res = {f[6:0], fi[0]}; e.rwe = 1; e.mem = d; e.fwe = 3'b001; e.fl[0] = f[7]; end
            5'd14: begin e.res = {f[3:0], f[7:4]}; e.rwe = 1; e.mem = d; end
            5'd16: begin e.res = f; e.res[b] = 1'b0; e.rwe = 1; e.mem = 1; end
            5'd17: begin e.res = f; e.res[b] = 1'b1; e.rwe = 1; e.mem = 1; end
            5'd18: begin e.sk = ~f[b]; end
            5'd19: begin e.sk = f[b]; end
            default: e = e;
        endcase
        if (e.fwe[2]) e.fl[2] = (e.res == 8'h00);
        return e;
    endfunction

    function automatic string tag_of(input logic [4:0] o);
        case (o)
            5'd0, 5'd1, 5'd20: return "R11/R2/R12";
            5'd2, 5'd25:       return "R4/R2/R12";
            5'd7, 5'd24:       return "R3/R2/R12";
            5'd3, 5'd4, 5'd5, 5'd6, 5'd8, 5'd9, 5'd10,
            5'd21, 5'd22, 5'd23: return "R5/R2/R12";
            5'd11, 5'd15:      return "R8/R2/R12";
            5'd12, 5'd13:      return "R6/R2/R12";
            5'd14:             return "R7/R2/R12";
            5'd16, 5'd17:      return "R9/R2/R12";
            5'd18, 5'd19:      return "R10/R2/R12";
            default:           return "R13/R12";
        endcase
    endfunction

    task automatic drive(input logic [4:0] o, input logic d, input logic [2:0] b,
                         input logic [7:0] f, input logic [7:0] w, input logic [2:0] fi);
        @(negedge clk);
        op = o; dst_bit = d; bit_sel = b; opnd = f; acc = w; flags_in = fi;
        in_valid = 1'b1;
        exp_q.push_back(model(o, d, b, f, w, fi));
        tag_q.push_back(tag_of(o));
    endtask

    // Monitor: pop one expected item per valid output and compare.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R1 unexpected valid", 32'(out_valid), 32'h0);
            end else begin
                exp_t  e;
                exp_t  a;
                string t;
                bit    ok;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = {result, result_we, result_to_mem, flags_out, flags_we, skip};
                ok = (a.rwe == e.rwe) && (a.fl == e.fl) && (a.fwe == e.fwe) && (a.sk == e.sk) &&
                     (!e.rwe || (a.res == e.res && a.mem == e.mem));
                chk(ok, t, 32'(a), 32'(e));
            end
        end
    end

    localparam logic [7:0] PF [8] = '{8'h00, 8'h0F, 8'hFF, 8'h80, 8'h3A, 8'h01, 8'h7F, 8'hC5};
    localparam logic [7:0] PW [8] = '{8'h00, 8'h01, 8'h01, 8'h80, 8'hC5, 8'h01, 8'h00, 8'h3A};

    initial begin
        // R1: reset state while issuing an add.
        in_valid = 1'b1; op = 5'd7; opnd = 8'hFF; acc = 8'h01; flags_in = 3'b111;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0 && result == 8'h00 && result_we == 1'b0 && result_to_mem == 1'b0 &&
            flags_out == 3'b000 && flags_we == 3'b000 && skip == 1'b0, "R1 reset state",
            {17'h0, out_valid, result, result_we, result_to_mem, flags_out, flags_we, skip}, 32'h0);
        rst_n = 1'b1;
        in_valid = 1'b0;

        // Sweep every code over operand patterns and both destinations.
        for (int o = 0; o < 32; o++)
            for (int p = 0; p < 8; p++)
                for (int d = 0; d < 2; d++)
                    drive(5'(o), 1'(d), 3'(p), PF[p], PW[p], 3'(p) ^ 3'(o) ^ 3'(d));

        // R9 / R10: bit operations at every position, both polarities.
        for (int b = 0; b < 8; b++)
            for (int o = 16; o < 20; o++) begin
                drive(5'(o), 1'b0, 3'(b), 8'hA5, 8'h00, 3'b010);
                drive(5'(o), 1'b1, 3'(b), 8'h5A, 8'hFF, 3'b101);
            end

        // R3 / R4: digit-carry and carry boundaries.
        drive(5'd7,  1'b0, 3'd0, 8'h08, 8'h08, 3'b000);
        drive(5'd24, 1'b0, 3'd0, 8'hF0, 8'h10, 3'b000);
        drive(5'd2,  1'b1, 3'd0, 8'h10, 8'h01, 3'b111);
        drive(5'd25, 1'b0, 3'd0, 8'h00, 8'h01, 3'b111);

        // R1 / R13: idle cycle gives no output.
        @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk(out_valid == 1'b0 && flags_we == 3'b000 && skip == 1'b0 && result_we == 1'b0,
            "R1 idle quiet", {28'h0, out_valid, skip, result_we, 1'b0}, 32'h0);
        chk(exp_q.size() == 0, "R1 all results produced", 32'(exp_q.size()), 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule